// File: doc/BRIEF.md
# Parallel Detect Negotiation Controller

This controller sits between the rate-specific link monitors of an Ethernet PHY and its management register file. It watches a link-good flag from the 10 Mb/s receiver and one from the 100 Mb/s receiver. It also watches a strobe that signals that a base page from a negotiating partner has been decoded. From these inputs it settles the operating mode and fills in the partner ability word. It drives the completion, partner-negotiates and parallel-detect-fault status bits.

When the partner sends fast link pulses, the decoded page is taken as the partner ability word. When the partner only sends a plain link signal, the block waits until exactly one rate monitor has reported good for a qualification period. It then completes by parallel detection and writes a synthesized ability word. Management writes to the restart bit force a silent period first, in which transmit data and link pulses are held off. After that, pulse bursts start again. A device strapped to come up in forced mode ignores negotiation until software clears and then sets the enable bit. All periods are parameters counted in clock cycles.

Top module: `pdet_neg_ctrl`

## Requirements
- R1: After a synchronous reset with `an_enable`=1 and `forced_boot`=0, every status output is 0 and `lp_ability` is 0x0000. `flp_tx_en` rises one cycle after reset is released.
- R2: While listening, if only `link100_good` is high for QUAL_CYC consecutive cycles, `an_complete` rises no sooner than QUAL_CYC and no later than QUAL_CYC+2 cycles after the link came up. At that point `lp_ability`=0x0081 and `link_mode`=2'b10.
- R3: While listening, if only `link10_good` stays high, completion comes by parallel detection with `lp_ability`=0x0021 and `link_mode`=2'b01.
- R4: After any parallel-detect completion, `lp_ability[4:0]` reads 5'b00001 and `lp_an_able` reads 0 while `an_complete` reads 1.
- R5: While listening, both link monitors high at once set `pd_fault` on the next cycle, and no completion happens while the conflict lasts.
- R6: `pd_fault` stays set until a cycle with `stat_rd`=1 and no conflict. A read in a cycle that still has the conflict leaves it set.
- R7: A one-cycle `restart_wr` pulse while armed makes `restart_bit` read 1 in the next cycle and 0 in the one after. In that later cycle `an_complete` reads 0 and the silent period begins. The pulse has no effect while not armed.
- R8: During the silent period `tx_silence`=1 and `flp_tx_en`=0 for exactly BREAK_CYC cycles. No completion occurs in that time, even with a good link. Then `flp_tx_en`=1.
- R9: If the link of the resolved mode drops while complete, `an_complete`, `link_mode` and `lp_ability` return to 0 and `flp_tx_en` returns to 1 in the next cycle. Negotiation then resumes.
- R10: After a reset with `forced_boot`=1, no listening, silencing or completion takes place until `an_enable` has been seen low and then high. Listening starts two cycles after the rise.
- R11: A `page_valid` strobe while listening completes on the next cycle with `lp_an_able`=1 and `lp_ability`=`page_word`. `link_mode` is 2'b10 when page bit 7 is set and 2'b01 otherwise. The strobe takes precedence over parallel detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Negotiation enable control bit level |
| forced_boot | input | 1 | Strap: device came up in forced mode (sampled in reset) |
| restart_wr | input | 1 | One-cycle write of 1 to the restart control bit |
| stat_rd | input | 1 | Read strobe of the status word holding the fault bit |
| link10_good | input | 1 | 10 Mb/s receiver reports valid link |
| link100_good | input | 1 | 100 Mb/s receiver reports valid link |
| page_valid | input | 1 | A partner base page was decoded this cycle |
| page_word | input | 16 | Decoded partner base page |
| lp_ability | output | 16 | Partner ability word |
| an_complete | output | 1 | Negotiation complete status |
| lp_an_able | output | 1 | Partner negotiates (0 after parallel detection) |
| pd_fault | output | 1 | Parallel detect fault, sticky until read |
| restart_bit | output | 1 | Restart control bit readback, self-clearing |
| tx_silence | output | 1 | Transmit data and link pulses held off |
| flp_tx_en | output | 1 | Fast link pulse bursts enabled (listening) |
| link_mode | output | 2 | Resolved mode: 00 none, 01 10 Mb/s, 10 100 Mb/s |

## Verification
The fault bit can be set by a rate conflict and cleared by a status read on the same clock edge, and setting must win. The bench holds both link monitors high while listening and pulses the read strobe for one cycle. The fault must still read 1 afterwards. Once the conflict is withdrawn, a second read must clear it, and a period with no conflict and no read must leave it set.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] PD_WORD_100 = 16'h0081;
  localparam logic [WORD_W-1:0] PD_WORD_10  = 16'h0021;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BREAK  = 2'd1,
    ST_LISTEN = 2'd2,
    ST_DONE   = 2'd3
  } neg_st_t;

  typedef enum logic [1:0] {
    LM_NONE = 2'b00,
    LM_10   = 2'b01,
    LM_100  = 2'b10
  } lmode_t;

endpackage

// File: rtl/pdet_break_timer.sv
module pdet_break_timer #(
  parameter int CYC = 187_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R8: a load always starts a full silent period
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == RELOAD));

endmodule

// File: rtl/pdet_link_qual.sv
module pdet_link_qual #(
  parameter int QUAL_CYC = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic link10,
  input  logic link100,
  output logic good10,
  output logic good100
);

  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] cnt;
  logic          sel_q;
  logic          single;

  assign single = link10 ^ link100;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= link100;
      if (clr || !single || (link100 != sel_q)) begin
        cnt <= '0;
      end else if (cnt != QMAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign good100 = (cnt == QMAX) &&  sel_q;
  assign good10  = (cnt == QMAX) && !sel_q;

  // R2: a qualified fast link was alone on the previous edge
  a_r2_qual_single: assert property (@(posedge clk) disable iff (rst)
    good100 |-> $past(link100 && !link10));

  // R3: a qualified slow link was alone on the previous edge
  a_r3_qual_single: assert property (@(posedge clk) disable iff (rst)
    good10 |-> $past(link10 && !link100));

endmodule

// File: rtl/pdet_neg_ctrl.sv
module pdet_neg_ctrl
  import pdet_pkg::*;
#(
  parameter int BREAK_CYC = 187_500_000,
  parameter int QUAL_CYC  = 6250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              an_enable,
  input  logic              forced_boot,
  input  logic              restart_wr,
  input  logic              stat_rd,
  input  logic              link10_good,
  input  logic              link100_good,
  input  logic              page_valid,
  input  logic [WORD_W-1:0] page_word,
  output logic [WORD_W-1:0] lp_ability,
  output logic              an_complete,
  output logic              lp_an_able,
  output logic              pd_fault,
  output logic              restart_bit,
  output logic              tx_silence,
  output logic              flp_tx_en,
  output logic [1:0]        link_mode
);

  localparam int RW = $clog2(BREAK_CYC + 2);

  neg_st_t st, st_d;
  lmode_t  mode_q;
  logic    en_q, armed;
  logic    tmr_load, tmr_expired;
  logic    q10, q100;
  logic    mode_lost, conflict;

  // Arming: forced start-up needs enable to go low, then high
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      armed <= an_enable && !forced_boot;
    end else begin
      en_q <= an_enable;
      if (!an_enable)  armed <= 1'b0;
      else if (!en_q)  armed <= 1'b1;
    end
  end

  // Restart bit: readable for one cycle, consumed by the FSM
  always_ff @(posedge clk) begin
    if (rst) restart_bit <= 1'b0;
    else     restart_bit <= restart_wr && armed;
  end

  pdet_break_timer #(.CYC(BREAK_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  pdet_link_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .clr     (st != ST_LISTEN),
    .link10  (link10_good),
    .link100 (link100_good),
    .good10  (q10),
    .good100 (q100)
  );

  assign mode_lost = ((mode_q == LM_100) && !link100_good) ||
                     ((mode_q == LM_10)  && !link10_good);
  assign conflict  = (st == ST_LISTEN) && link10_good && link100_good;

  always_comb begin
    st_d     = st;
    tmr_load = 1'b0;
    if (!armed) begin
      st_d = ST_IDLE;
    end else if (restart_bit) begin
      st_d     = ST_BREAK;
      tmr_load = 1'b1;
    end else begin
      case (st)
        ST_IDLE:   st_d = ST_LISTEN;
        ST_BREAK:  if (tmr_expired) st_d = ST_LISTEN;
        ST_LISTEN: if (page_valid || q10 || q100) st_d = ST_DONE;
        ST_DONE:   if (mode_lost) st_d = ST_LISTEN;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mode_q      <= LM_NONE;
      lp_ability  <= '0;
      an_complete <= 1'b0;
      lp_an_able  <= 1'b0;
      tx_silence  <= 1'b0;
      flp_tx_en   <= 1'b0;
    end else begin
      st         <= st_d;
      tx_silence <= (st_d == ST_BREAK);
      flp_tx_en  <= (st_d == ST_LISTEN);
      if (st_d != ST_DONE) begin
        mode_q      <= LM_NONE;
        lp_ability  <= '0;
        an_complete <= 1'b0;
        lp_an_able  <= 1'b0;
      end else if (st != ST_DONE) begin
        an_complete <= 1'b1;
        if (page_valid) begin
          lp_ability <= page_word;
          lp_an_able <= 1'b1;
          mode_q     <= page_word[7] ? LM_100 : LM_10;
        end else if (q100) begin
          lp_ability <= PD_WORD_100;
          lp_an_able <= 1'b0;
          mode_q     <= LM_100;
        end else begin
          lp_ability <= PD_WORD_10;
          lp_an_able <= 1'b0;
          mode_q     <= LM_10;
        end
      end
    end
  end

  // Fault: a conflict sets it, a read clears it, setting wins
  always_ff @(posedge clk) begin
    if (rst)           pd_fault <= 1'b0;
    else if (conflict) pd_fault <= 1'b1;
    else if (stat_rd)  pd_fault <= 1'b0;
  end

  assign link_mode = mode_q;

  // Checker state: length of the current silent run
  logic [RW-1:0] silence_run;
  always_ff @(posedge clk) begin
    if (rst || restart_bit || !tx_silence) silence_run <= '0;
    else                                    silence_run <= silence_run + 1'b1;
    if (!rst)
      a_r8_break_len: assert (silence_run <= RW'(BREAK_CYC))
        else $error("silent period longer than BREAK_CYC");
  end

  a_r2_word_100: assert property (@(posedge clk) disable iff (rst)
    (an_complete && !lp_an_able && link_mode == 2'b10) |-> (lp_ability == 16'h0081));

  a_r3_word_10: assert property (@(posedge clk) disable iff (rst)
    (an_complete && !lp_an_able && link_mode == 2'b01) |-> (lp_ability == 16'h0021));

  a_r4_selector: assert property (@(posedge clk) disable iff (rst)
    (an_complete && !lp_an_able) |-> (lp_ability[4:0] == 5'b00001));

  a_r5_fault_set: assert property (@(posedge clk) disable iff (rst)
    conflict |=> pd_fault);

  a_r6_fault_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !conflict) |=> !pd_fault);

  a_r7_restart_taken: assert property (@(posedge clk) disable iff (rst)
    (restart_bit && armed) |=> (tx_silence && !an_complete && !restart_bit) || $past(restart_wr));

  a_r8_silent_no_done: assert property (@(posedge clk) disable iff (rst)
    tx_silence |-> (!an_complete && !flp_tx_en));

  a_r10_unarmed_idle: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (!flp_tx_en && !tx_silence && !an_complete));

endmodule

// File: tb/pdet_neg_ctrl_test.sv
`timescale 1ns/1ps
module pdet_neg_ctrl_test;

  localparam int BREAK_CYC = 20;
  localparam int QUAL_CYC  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        an_enable = 1'b1, forced_boot = 1'b0, restart_wr = 1'b0, stat_rd = 1'b0;
  logic        link10_good = 1'b0, link100_good = 1'b0, page_valid = 1'b0;
  logic [15:0] page_word = '0;
  logic [15:0] lp_ability;
  logic        an_complete, lp_an_able, pd_fault, restart_bit, tx_silence, flp_tx_en;
  logic [1:0]  link_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pdet_neg_ctrl #(.BREAK_CYC(BREAK_CYC), .QUAL_CYC(QUAL_CYC)) uut (
    .clk(clk), .rst(rst), .an_enable(an_enable), .forced_boot(forced_boot),
    .restart_wr(restart_wr), .stat_rd(stat_rd), .link10_good(link10_good),
    .link100_good(link100_good), .page_valid(page_valid), .page_word(page_word),
    .lp_ability(lp_ability), .an_complete(an_complete), .lp_an_able(lp_an_able),
    .pd_fault(pd_fault), .restart_bit(restart_bit), .tx_silence(tx_silence),
    .flp_tx_en(flp_tx_en), .link_mode(link_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic forced);
    rst = 1'b1; forced_boot = forced; an_enable = 1'b1;
    link10_good = 0; link100_good = 0; page_valid = 0; restart_wr = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int i = 0; i < QUAL_CYC + 20; i++) begin
      @(negedge clk); n++;
      if (an_complete) break;
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 complete", an_complete, 0);
    chk("R1 fault", pd_fault, 0);
    chk("R1 lp_ability", lp_ability, 16'h0000);
    chk("R1 restart_bit", restart_bit, 0);
    chk("R1 silence", tx_silence, 0);
    chk("R1 mode", link_mode, 0);
    @(negedge clk);
    chk("R1 listening", flp_tx_en, 1);
  endtask

  task automatic t_pd100;
    int n;
    link100_good = 1;
    wait_done(n);
    chk("R2 window", (n >= QUAL_CYC && n <= QUAL_CYC + 2), 1);
    chk("R2 complete", an_complete, 1);
    chk("R2 word", lp_ability, 16'h0081);
    chk("R2 mode", link_mode, 2'b10);
    chk("R4 selector", lp_ability[4:0], 5'b00001);
    chk("R4 partner able", lp_an_able, 0);
  endtask

  task automatic t_loss_then_pd10;
    int n;
    link100_good = 0;
    @(negedge clk);
    chk("R9 complete cleared", an_complete, 0);
    chk("R9 listening", flp_tx_en, 1);
    chk("R9 mode", link_mode, 0);
    chk("R9 word", lp_ability, 16'h0000);
    link10_good = 1;
    wait_done(n);
    chk("R3 complete", an_complete, 1);
    chk("R3 word", lp_ability, 16'h0021);
    chk("R3 mode", link_mode, 2'b01);
    chk("R4 selector 10", lp_ability[4:0], 5'b00001);
    chk("R4 able 10", lp_an_able, 0);
  endtask

  task automatic t_fault;
    link10_good = 0;
    @(negedge clk);
    link10_good = 1; link100_good = 1;
    @(negedge clk);
    chk("R5 fault set", pd_fault, 1);
    repeat (QUAL_CYC + 4) @(negedge clk);
    chk("R5 no completion", an_complete, 0);
    stat_rd = 1;            // read collides with an active conflict
    @(negedge clk);
    stat_rd = 0;
    chk("R6 set wins over read", pd_fault, 1);
    link10_good = 0; link100_good = 0;
    repeat (2) @(negedge clk);
    chk("R6 sticky", pd_fault, 1);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk("R6 cleared by read", pd_fault, 0);
  endtask

  task automatic t_restart;
    int n, sil;
    bit early;
    link100_good = 1;
    wait_done(n);
    chk("R7 precondition", an_complete, 1);
    restart_wr = 1;
    @(negedge clk);
    restart_wr = 0;
    chk("R7 bit reads 1", restart_bit, 1);
    @(negedge clk);
    chk("R7 bit self clears", restart_bit, 0);
    chk("R7 complete cleared", an_complete, 0);
    sil = 0; early = 0;
    for (int i = 0; i < BREAK_CYC + 10; i++) begin
      if (!tx_silence) break;
      sil++;
      if (an_complete || flp_tx_en) early = 1;
      @(negedge clk);
    end
    chk("R8 silent length", sil, BREAK_CYC);
    chk("R8 quiet during break", early, 0);
    chk("R8 bursts resume", flp_tx_en, 1);
    link100_good = 0;
  endtask

  task automatic t_page;
    @(negedge clk);
    page_word = 16'h41E1; page_valid = 1; link100_good = 1;
    @(negedge clk);
    page_valid = 0;
    chk("R11 complete", an_complete, 1);
    chk("R11 partner able", lp_an_able, 1);
    chk("R11 word", lp_ability, 16'h41E1);
    chk("R11 mode", link_mode, 2'b10);
  endtask

  task automatic t_forced;
    do_reset(1'b1);
    link100_good = 1;
    repeat (QUAL_CYC + 4) @(negedge clk);
    chk("R10 no listening", flp_tx_en, 0);
    chk("R10 no completion", an_complete, 0);
    restart_wr = 1;
    @(negedge clk);
    restart_wr = 0;
    chk("R7 ignored unarmed", restart_bit, 0);
    @(negedge clk);
    chk("R10 no silence", tx_silence, 0);
    an_enable = 0;
    repeat (2) @(negedge clk);
    an_enable = 1;
    repeat (2) @(negedge clk);
    chk("R10 listening after rearm", flp_tx_en, 1);
  endtask

  initial begin
    t_reset();
    t_pd100();
    t_loss_then_pd10();
    t_fault();
    t_restart();
    t_page();
    t_forced();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule